// File: doc/BRIEF.md
# Parallel Flash Bus Control Front End

This block sits between the asynchronous control pins of a byte-wide parallel NOR-style memory and its internal logic. All pins are assumed to be already synchronised to a fast system clock. The block oversamples chip enable, output enable and write enable. It rejects strobe pulses that are too short, and decodes the filtered levels into one of four bus operations: standby, output disable, read and write.

On a read, the block drives the byte bus with array data. In signature mode it drives an identification code instead. On a write, the address is taken when the pair of chip enable and write enable first becomes jointly low. The data is taken when that pair stops being jointly low. The block then passes both values to a downstream command interpreter as a single-cycle pulse.

An idle timer raises a low-power indication once the bus has been quiet for long enough. A busy flag from the program/erase engine holds that indication off.

Top module: `pflash_front`

## Requirements
- R1: `op_o` reports the filtered operation: 0 standby (CE high), 3 write (CE low, WE low, OE high), 2 read (CE low, OE low, WE high), 1 output disable (every other case with CE low).
- R2: During a read, `dq_oe_o` is 1 and `dq_o` equals `array_data_i` when signature mode is off.
- R3: `dq_oe_o` is 0 whenever filtered OE is high or filtered CE is high.
- R4: A write's address is the `addr_i` value present when the later of CE and WE falls. Address changes after that point have no effect on it.
- R5: A write's data is the `dq_i` value present when the earlier of CE and WE rises. Data changes after that point have no effect on it.
- R6: Each completed write produces exactly one single-cycle `wr_valid_o` pulse carrying the captured address and data.
- R7: A write during which filtered OE is low at any point produces no `wr_valid_o` pulse.
- R8: A CE or WE level held for fewer than `GLITCH_CYC` clock cycles changes neither `op_o` nor the bus, and starts no write.
- R9: `auto_sby_o` rises once the filtered strobes and `addr_i` have been unchanged for `IDLE_CYC` cycles. It drops in the cycle after any change to them.
- R10: While `auto_sby_o` is 1 during a read, the bus keeps driving the read data.
- R11: While `busy_i` is 1, `auto_sby_o` is 0. It returns as soon as `busy_i` drops, provided the idle time has already elapsed.
- R12: With `sig_mode_i` set and `addr_i[1]`=0, a read returns 8'h20 when `addr_i[0]`=0 and 8'hAC when `addr_i[0]`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr_i | input | ADDR_W | Address bus |
| dq_i | input | DATA_W | Incoming byte bus |
| array_data_i | input | DATA_W | Read data from the memory array |
| sig_mode_i | input | 1 | High-voltage detect flag, selects signature reads |
| busy_i | input | 1 | Program/erase engine busy |
| dq_o | output | DATA_W | Outgoing byte bus value |
| dq_oe_o | output | 1 | Bus drive enable (0 = high impedance) |
| op_o | output | 2 | Decoded bus operation |
| wr_valid_o | output | 1 | Single-cycle write handoff pulse |
| wr_addr_o | output | ADDR_W | Captured write address |
| wr_data_o | output | DATA_W | Captured write data |
| auto_sby_o | output | 1 | Automatic standby indication |

## Verification
The assertions check the following on every cycle: the handoff pulse never lasts two cycles, the bus is never driven in standby, busy always masks the standby indication, an address change always clears it, the manufacturer code appears on any qualifying signature read, and a drive enable never rises unless the raw pins asked for a read over the preceding samples. Only the bench scenarios can show the rest. That covers which address and data a write actually captures when the bus changes around the composite edges, the suppression of a write spoiled by OE, the rejection of short strobe pulses, and the exact idle time before standby.

// File: rtl/pflash_pkg.sv
package pflash_pkg;
   typedef enum logic [1:0] {
      OP_STANDBY = 2'd0,
      OP_OUTDIS  = 2'd1,
      OP_READ    = 2'd2,
      OP_WRITE   = 2'd3
   } bus_op_e;
endpackage

// File: rtl/pflash_strobe_filter.sv
module pflash_strobe_filter #(
   parameter int GLITCH_CYC = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic filt_o
);
   generate
      if (GLITCH_CYC == 0) begin : g_pass
         assign filt_o = raw_i;
      end else begin : g_count
         localparam int CW = $clog2(GLITCH_CYC + 1);
         localparam logic [CW-1:0] LAST = CW'(GLITCH_CYC - 1);
         logic [CW-1:0] cnt_q;
         logic          lvl_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lvl_q <= 1'b1;
               cnt_q <= '0;
            end else if (raw_i != lvl_q) begin
               if (cnt_q == LAST) begin
                  lvl_q <= raw_i;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end else begin
               cnt_q <= '0;
            end
         end
         assign filt_o = lvl_q;
      end
   endgenerate
endmodule

// File: rtl/pflash_wr_capture.sv
module pflash_wr_capture #(
   parameter int ADDR_W = 22,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_f,
   input  logic              oe_f,
   input  logic              we_f,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] dq_i,
   output logic              wr_valid_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [DATA_W-1:0] wr_data_o
);
   logic              both_low;
   logic              both_low_q;
   logic              spoil_q;
   logic [ADDR_W-1:0] addr_lat_q;

   assign both_low = !ce_f && !we_f;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         both_low_q <= 1'b0;
         spoil_q    <= 1'b0;
         addr_lat_q <= '0;
         wr_valid_o <= 1'b0;
         wr_addr_o  <= '0;
         wr_data_o  <= '0;
      end else begin
         both_low_q <= both_low;
         wr_valid_o <= 1'b0;
         if (both_low && !both_low_q) begin
            addr_lat_q <= addr_i;
            spoil_q    <= !oe_f;
         end else if (both_low && !oe_f) begin
            spoil_q <= 1'b1;
         end
         if (!both_low && both_low_q && !spoil_q) begin
            wr_valid_o <= 1'b1;
            wr_addr_o  <= addr_lat_q;
            wr_data_o  <= dq_i;
         end
      end
   end
endmodule

// File: rtl/pflash_idle_timer.sv
module pflash_idle_timer #(
   parameter int ADDR_W   = 22,
   parameter int IDLE_CYC = 30
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        strb_f,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              busy_i,
   output logic              auto_sby_o
);
   localparam int TW = $clog2(IDLE_CYC + 1);
   localparam logic [TW-1:0] TOP = TW'(IDLE_CYC);

   logic [2:0]        strb_q;
   logic [ADDR_W-1:0] addr_q;
   logic [TW-1:0]     quiet_q;
   logic              moved;

   assign moved = (strb_f != strb_q) || (addr_i != addr_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strb_q  <= 3'b111;
         addr_q  <= '0;
         quiet_q <= '0;
      end else begin
         strb_q <= strb_f;
         addr_q <= addr_i;
         if (moved)
            quiet_q <= '0;
         else if (quiet_q != TOP)
            quiet_q <= quiet_q + 1'b1;
      end
   end

   assign auto_sby_o = (quiet_q == TOP) && !busy_i;
endmodule

// File: rtl/pflash_front.sv
module pflash_front
   import pflash_pkg::*;
#(
   parameter int          ADDR_W     = 22,
   parameter int          DATA_W     = 8,
   parameter int          GLITCH_CYC = 3,
   parameter int          IDLE_CYC   = 30,
   parameter logic [7:0]  MFR_CODE   = 8'h20,
   parameter logic [7:0]  DEV_CODE   = 8'hAC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] dq_i,
   input  logic [DATA_W-1:0] array_data_i,
   input  logic              sig_mode_i,
   input  logic              busy_i,
   output logic [DATA_W-1:0] dq_o,
   output logic              dq_oe_o,
   output logic [1:0]        op_o,
   output logic              wr_valid_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [DATA_W-1:0] wr_data_o,
   output logic              auto_sby_o
);
   localparam int NSTRB = 3;

   generate
      if (ADDR_W < 2)       begin : g_bad_aw   $error("ADDR_W must be at least 2");   end
      if (DATA_W < 8)       begin : g_bad_dw   $error("DATA_W must be at least 8");   end
      if (GLITCH_CYC < 0)   begin : g_bad_gl   $error("GLITCH_CYC must be >= 0");     end
      if (IDLE_CYC < 2)     begin : g_bad_idle $error("IDLE_CYC must be at least 2"); end
   endgenerate

   logic [NSTRB-1:0] strb_raw;
   logic [NSTRB-1:0] strb_f;
   logic             ce_f, oe_f, we_f;
   bus_op_e          op;

   assign strb_raw = {ce_n, oe_n, we_n};

   generate
      for (genvar i = 0; i < NSTRB; i++) begin : g_filt
         pflash_strobe_filter #(.GLITCH_CYC(GLITCH_CYC)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (strb_raw[i]),
            .filt_o (strb_f[i])
         );
      end
   endgenerate

   assign {ce_f, oe_f, we_f} = strb_f;

   always_comb begin
      if (ce_f)
         op = OP_STANDBY;
      else if (!we_f && oe_f)
         op = OP_WRITE;
      else if (!oe_f && we_f)
         op = OP_READ;
      else
         op = OP_OUTDIS;
   end

   assign op_o    = op;
   assign dq_oe_o = !ce_f && !oe_f && we_f;

   always_comb begin
      if (sig_mode_i) begin
         if (addr_i[1])
            dq_o = '0;
         else if (addr_i[0])
            dq_o = DATA_W'(DEV_CODE);
         else
            dq_o = DATA_W'(MFR_CODE);
      end else begin
         dq_o = array_data_i;
      end
   end

   pflash_wr_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
      .clk        (clk),
      .rst_n      (rst_n),
      .ce_f       (ce_f),
      .oe_f       (oe_f),
      .we_f       (we_f),
      .addr_i     (addr_i),
      .dq_i       (dq_i),
      .wr_valid_o (wr_valid_o),
      .wr_addr_o  (wr_addr_o),
      .wr_data_o  (wr_data_o)
   );

   pflash_idle_timer #(.ADDR_W(ADDR_W), .IDLE_CYC(IDLE_CYC)) u_idle (
      .clk        (clk),
      .rst_n      (rst_n),
      .strb_f     (strb_f),
      .addr_i     (addr_i),
      .busy_i     (busy_i),
      .auto_sby_o (auto_sby_o)
   );
endmodule

// File: rtl/pflash_front_chk.sv
module pflash_front_chk
   import pflash_pkg::*;
#(
   parameter int         ADDR_W     = 22,
   parameter int         DATA_W     = 8,
   parameter int         GLITCH_CYC = 3,
   parameter logic [7:0] MFR_CODE   = 8'h20
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce_n,
   input logic              oe_n,
   input logic              we_n,
   input logic [ADDR_W-1:0] addr_i,
   input logic              sig_mode_i,
   input logic              busy_i,
   input logic [DATA_W-1:0] dq_o,
   input logic              dq_oe_o,
   input logic [1:0]        op_o,
   input logic              wr_valid_o,
   input logic              auto_sby_o
);
   AST_ONE_CYCLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid_o |=> !wr_valid_o); // R6

   AST_STANDBY_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
      (op_o == OP_STANDBY) |-> !dq_oe_o); // R3

   AST_BUSY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i |-> !auto_sby_o); // R11

   AST_ADDR_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_i != $past(addr_i)) |=> !auto_sby_o); // R9

   AST_SIG_MFR: assert property (@(posedge clk) disable iff (!rst_n)
      (dq_oe_o && sig_mode_i && !addr_i[1] && !addr_i[0]) |-> (dq_o == DATA_W'(MFR_CODE))); // R12

   generate
      if (GLITCH_CYC >= 2) begin : g_glitch_chk
         AST_READ_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(dq_oe_o) |-> ($past(!oe_n) && $past(!oe_n, 2) && $past(!ce_n) && $past(!ce_n, 2))); // R8
      end
   endgenerate
endmodule

bind pflash_front pflash_front_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GLITCH_CYC(GLITCH_CYC), .MFR_CODE(MFR_CODE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
   .addr_i(addr_i), .sig_mode_i(sig_mode_i), .busy_i(busy_i),
   .dq_o(dq_o), .dq_oe_o(dq_oe_o), .op_o(op_o),
   .wr_valid_o(wr_valid_o), .auto_sby_o(auto_sby_o)
);

// File: tb/pflash_front_test.sv
module pflash_front_test;
   localparam int CLK_P = 10;
   localparam int AW    = 22;
   localparam int DW    = 8;
   localparam int GL    = 3;
   localparam int IDLE  = 30;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          ce_n, oe_n, we_n;
   logic [AW-1:0] addr_i;
   logic [DW-1:0] dq_i, array_data_i;
   logic          sig_mode_i, busy_i;
   logic [DW-1:0] dq_o;
   logic          dq_oe_o;
   logic [1:0]    op_o;
   logic          wr_valid_o;
   logic [AW-1:0] wr_addr_o;
   logic [DW-1:0] wr_data_o;
   logic          auto_sby_o;

   int            n_chk = 0;
   int            n_bad = 0;
   int            n_pulse = 0;
   logic [AW-1:0] last_a;
   logic [DW-1:0] last_d;
   bit            done = 0;

   always #(CLK_P/2) clk = ~clk;

   pflash_front #(.ADDR_W(AW), .DATA_W(DW), .GLITCH_CYC(GL), .IDLE_CYC(IDLE)) uut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .addr_i(addr_i), .dq_i(dq_i), .array_data_i(array_data_i),
      .sig_mode_i(sig_mode_i), .busy_i(busy_i), .dq_o(dq_o), .dq_oe_o(dq_oe_o),
      .op_o(op_o), .wr_valid_o(wr_valid_o), .wr_addr_o(wr_addr_o),
      .wr_data_o(wr_data_o), .auto_sby_o(auto_sby_o)
   );

   always @(negedge clk) begin
      if (rst_n && wr_valid_o) begin
         n_pulse = n_pulse + 1;
         last_a  = wr_addr_o;
         last_d  = wr_data_o;
      end
   end

   function automatic logic [1:0] exp_op(logic ce, logic oe, logic we);
      if (ce)           return 2'd0;
      if (!we && oe)    return 2'd3;
      if (!oe && we)    return 2'd2;
      return 2'd1;
   endfunction

   function automatic logic [DW-1:0] exp_dq(logic sig, logic [AW-1:0] a, logic [DW-1:0] arr);
      if (!sig)  return arr;
      if (a[1])  return '0;
      return a[0] ? 8'hAC : 8'h20;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit spoil);
      ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1; addr_i = ~a; step(GL + 3);
      addr_i = a; we_n = 1'b0; step(GL + 4);
      chk(op_o == 2'd3, "R1 write op", op_o, 3);
      addr_i = a ^ 22'h15A5A;   // R4: changes after the later fall are ignored
      dq_i = d;
      if (spoil) begin
         oe_n = 1'b0; step(GL + 3); oe_n = 1'b1; step(GL + 3);
      end else begin
         step(2);
      end
      we_n = 1'b1; step(GL + 4);
      dq_i = ~d;                // R5: changes after the earlier rise are ignored
      step(GL + 3);
      ce_n = 1'b1; step(GL + 4);
   endtask

   initial begin
      automatic int p0;
      void'($urandom(32'h5EED_1234));
      rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
      addr_i = '0; dq_i = '0; array_data_i = '0; sig_mode_i = 1'b0; busy_i = 1'b0;
      step(3);
      chk(dq_oe_o == 1'b0, "R3 reset hiz", dq_oe_o, 0);
      chk(wr_valid_o == 1'b0, "R6 reset pulse", wr_valid_o, 0);
      chk(auto_sby_o == 1'b0, "R9 reset standby", auto_sby_o, 0);
      chk(op_o == 2'd0, "R1 reset op", op_o, 0);
      rst_n = 1'b1; step(2);

      // R2 read
      array_data_i = 8'h5A; addr_i = 22'h1234; ce_n = 1'b0; oe_n = 1'b0; step(GL + 2);
      chk(op_o == 2'd2, "R1 read op", op_o, 2);
      chk(dq_oe_o == 1'b1, "R2 read drive", dq_oe_o, 1);
      chk(dq_o == 8'h5A, "R2 read data", dq_o, 8'h5A);
      // R3 output disable and standby
      oe_n = 1'b1; step(GL + 2);
      chk(op_o == 2'd1, "R1 outdis op", op_o, 1);
      chk(dq_oe_o == 1'b0, "R3 oe high hiz", dq_oe_o, 0);
      oe_n = 1'b0; ce_n = 1'b1; step(GL + 2);
      chk(dq_oe_o == 1'b0, "R3 ce high hiz", dq_oe_o, 0);

      // R12 signature
      sig_mode_i = 1'b1; ce_n = 1'b0; addr_i = 22'h0; step(GL + 2);
      chk(dq_o == 8'h20, "R12 mfr code", dq_o, 8'h20);
      addr_i = 22'h1; step(1);
      chk(dq_o == 8'hAC, "R12 dev code", dq_o, 8'hAC);
      sig_mode_i = 1'b0; ce_n = 1'b1; step(GL + 2);

      // R8 glitch on CE while OE low
      ce_n = 1'b0;
      for (int i = 0; i < GL - 1; i++) begin
         step(1);
         chk(dq_oe_o == 1'b0, "R8 ce glitch no drive", dq_oe_o, 0);
      end
      ce_n = 1'b1; step(GL + 2);
      chk(op_o == 2'd0, "R8 ce glitch op", op_o, 0);

      // R8 glitch on WE during CE low / OE high
      oe_n = 1'b1; ce_n = 1'b0; step(GL + 3);
      p0 = n_pulse;
      we_n = 1'b0; step(GL - 1); we_n = 1'b1; step(GL + 4);
      chk(n_pulse == p0, "R8 we glitch no write", n_pulse, p0);
      chk(op_o == 2'd1, "R8 we glitch op", op_o, 1);
      ce_n = 1'b1; step(GL + 3);

      // R4 R5 R6 write
      p0 = n_pulse;
      do_write(22'h2A5C3, 8'hC7, 1'b0);
      chk(n_pulse == p0 + 1, "R6 one pulse", n_pulse, p0 + 1);
      chk(last_a == 22'h2A5C3, "R4 addr at later fall", last_a, 22'h2A5C3);
      chk(last_d == 8'hC7, "R5 data at earlier rise", last_d, 8'hC7);
      // R7 spoiled write
      p0 = n_pulse;
      do_write(22'h00F0F, 8'h3C, 1'b1);
      chk(n_pulse == p0, "R7 oe low no pulse", n_pulse, p0);

      // R9 R10 idle standby in read
      array_data_i = 8'h96; addr_i = 22'h777; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
      step(GL + 2);
      chk(auto_sby_o == 1'b0, "R9 not yet idle", auto_sby_o, 0);
      step(IDLE + 4);
      chk(auto_sby_o == 1'b1, "R9 idle standby", auto_sby_o, 1);
      chk(dq_oe_o == 1'b1 && dq_o == 8'h96, "R10 drive in standby", dq_o, 8'h96);
      addr_i = 22'h778; step(1);
      chk(auto_sby_o == 1'b0, "R9 wake on addr", auto_sby_o, 0);
      // R11 busy
      busy_i = 1'b1; step(IDLE + GL + 4);
      chk(auto_sby_o == 1'b0, "R11 busy blocks", auto_sby_o, 0);
      busy_i = 1'b0; step(1);
      chk(auto_sby_o == 1'b1, "R11 release", auto_sby_o, 1);

      // random levels, R1 R2 R3 R12
      for (int it = 0; it < 60; it++) begin
         automatic logic [2:0] s = 3'($urandom);
         ce_n = s[2]; oe_n = s[1]; we_n = s[0];
         addr_i = AW'($urandom); array_data_i = DW'($urandom);
         sig_mode_i = ($urandom % 4) == 0;
         step(GL + 2);
         chk(op_o == exp_op(s[2], s[1], s[0]), "R1 random op", op_o, exp_op(s[2], s[1], s[0]));
         chk(dq_oe_o == (exp_op(s[2], s[1], s[0]) == 2'd2), "R3 random drive", dq_oe_o,
             exp_op(s[2], s[1], s[0]) == 2'd2);
         if (dq_oe_o)
            chk(dq_o == exp_dq(sig_mode_i, addr_i, array_data_i), "R12 random data", dq_o,
                exp_dq(sig_mode_i, addr_i, array_data_i));
      end

      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule